// File: doc/BRIEF.md
# Address-Space Page Mapper with Per-Space I/O Gate

This block sits between the processor network and the memory and I/O fabric. Each request carries an address-space number and a virtual address. The block splits the address into a page index and a 16-bit offset. It looks up a page-table entry selected by the pair (space, page) and forms the physical address from the entry's frame number and the untouched offset.

I/O requests must also pass a permission bitmap. The bitmap holds one bit per device for every address space, and the device number is the page index of the access. Every request produces exactly one outcome one clock later: either a translated request or a fault with a cause code.

Both tables are loaded and read back through a small register window. That window is decoded on physical addresses against a base value supplied on a configuration input, so it never goes through translation. Register accesses complete through a one-cycle pipeline of their own, which acknowledges on the following cycle.

The page count per space is a parameter. The default of 32 pages (2MB per space) keeps elaboration small. A page-index width of 9 gives 512 pages of 64kB, which is 32MB per space, across 64 spaces.

Two enumerated state machines control the block.

The translation stage has two states:
- `XS_EMPTY`: nothing is in flight.
- `XS_LOOKUP`: a request was captured on the last edge.

Its transitions are:
- take: to `XS_LOOKUP` whenever `req_valid` is high.
- drain: to `XS_EMPTY` when `req_valid` is low.

The register port has three states:
- `RS_IDLE`: no access is completing.
- `RS_READ`: a window hit read is completing.
- `RS_WRITE`: a window hit write is completing.

Its transitions are:
- hit-read: to `RS_READ` on a hit with `reg_we` low.
- hit-write: to `RS_WRITE` on a hit with `reg_we` high.
- none: back to `RS_IDLE` on no hit or no access.

Top module: `asmap_top`

## Requirements
- R1: After reset, `out_valid`, `flt_valid` and `reg_ack` are low, and every I/O permission bit is clear, so an I/O access in a space whose bitmap was never written faults with cause 2.
- R2: A request sampled on `req_valid` at a clock edge yields its outcome in the cycle right after that edge. On success, `out_pa` = {frame number, `req_va[15:0]`}, and `out_we` and `out_io` repeat the request's flags.
- R3: The page-table entry is selected by {`req_asid`, `req_va[15+P:16]`}, where P is the page-index width (default 5). The same virtual address in two spaces maps independently.
- R4: A virtual address with any bit set at or above bit 16+P is out of range. It raises `flt_valid` with cause 1 and no `out_valid`.
- R5: An I/O request (`req_io`=1) to page d of space s needs permission bit d of row s; otherwise it faults with cause 2. Memory requests ignore the bitmap.
- R6: An entry whose valid bit (bit `AW-16` of the entry, i.e. bit 16) is 0 faults with cause 3.
- R7: Fault priority is range (1), then I/O denied (2), then unmapped (3). Cause 0 means no fault.
- R8: A register access hits only when `reg_addr[31:18]` equals `cfg_base[31:18]`. A miss gives no acknowledge and writes nothing.
- R9: In the window, `reg_addr[17]`=0 selects the page table at word {space, page} in `reg_addr[12:2]`, with data {valid at bit 16, frame in bits 15:0}. `reg_addr[17]`=1 selects the bitmap row for the space in `reg_addr[7:2]`, with bit d meaning device d. A hit is acknowledged one cycle later, with `reg_rdata` carrying the entry for reads.
- R10: `out_valid` and `flt_valid` are never high together, and both are low in a cycle that follows an edge with no request.
- R11: Requests on consecutive cycles each produce their own outcome on consecutive cycles.
- R12: A table write and a translation that read the same entry at the same edge give the translation the entry's old value. The new value applies from the next request on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | 32 | Physical base of the register window (bits 31:18 used) |
| req_valid | input | 1 | Translation request present |
| req_asid | input | 6 | Address-space number |
| req_va | input | 32 | Virtual address |
| req_we | input | 1 | Request is a write |
| req_io | input | 1 | Request targets an I/O device |
| out_valid | output | 1 | Translated request issued |
| out_pa | output | 32 | Physical address |
| out_we | output | 1 | Write flag of the issued request |
| out_io | output | 1 | I/O flag of the issued request |
| flt_valid | output | 1 | Request faulted |
| flt_cause | output | 2 | 0 none, 1 range, 2 I/O denied, 3 unmapped |
| reg_valid | input | 1 | Register access present |
| reg_we | input | 1 | Register access is a write |
| reg_addr | input | 32 | Physical register address |
| reg_wdata | input | 32 | Register write data |
| reg_ack | output | 1 | Window access completed |
| reg_rdata | output | 32 | Read data for a completed read |

## Verification
The bound checker watches the timing contract on every cycle:
- a request is followed by exactly one outcome, and an idle cycle by none;
- a success and a fault never appear together;
- the offset survives translation;
- out-of-range addresses always give cause 1, and memory requests never give cause 2;
- the window acknowledges exactly the hits.

Only the bench's scenarios can show the table-dependent behaviour:
- the right frame is chosen per space;
- bitmap bits gate the right device;
- the fault causes are ranked in order;
- a missed window write leaves state untouched;
- a write racing a lookup returns the old entry.

// File: rtl/asmap_pkg.sv
`timescale 1ns/1ps
package asmap_pkg;

    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_RANGE    = 2'd1,
        FLT_IO_DENY  = 2'd2,
        FLT_UNMAPPED = 2'd3
    } flt_cause_e;

    typedef enum logic {
        XS_EMPTY  = 1'b0,
        XS_LOOKUP = 1'b1
    } xl_state_e;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_READ  = 2'd1,
        RS_WRITE = 2'd2
    } rg_state_e;

endpackage

// File: rtl/asmap_ptab.sv
`timescale 1ns/1ps
// Page-table storage: one lookup read port, one register write port and
// one register read-back port, all synchronous (block-RAM style).
module asmap_ptab #(
    parameter int IDX_W = 11,
    parameter int EW    = 17
) (
    input  logic             clk,
    input  logic             lk_en,
    input  logic [IDX_W-1:0] lk_idx,
    output logic [EW-1:0]    lk_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [EW-1:0]    wr_data,
    input  logic             rb_en,
    input  logic [IDX_W-1:0] rb_idx,
    output logic [EW-1:0]    rb_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [EW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
        if (lk_en) begin
            lk_data <= mem[lk_idx];
        end
        if (rb_en) begin
            rb_data <= mem[rb_idx];
        end
    end
endmodule

// File: rtl/asmap_perm.sv
`timescale 1ns/1ps
// Per-space device permission rows; cleared by reset (deny all).
module asmap_perm #(
    parameter int ROW_W = 6,
    parameter int COLS  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_en,
    input  logic [ROW_W-1:0] lk_row,
    output logic [COLS-1:0]  lk_data,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [COLS-1:0]  wr_data,
    input  logic             rb_en,
    input  logic [ROW_W-1:0] rb_row,
    output logic [COLS-1:0]  rb_data
);
    localparam int ROWS = 1 << ROW_W;

    logic [COLS-1:0] row_arr [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [COLS-1:0] row_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                row_q <= '0;
            end else if (wr_en && (wr_row == ROW_W'(r))) begin
                row_q <= wr_data;
            end
        end
        assign row_arr[r] = row_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_data <= '0;
            rb_data <= '0;
        end else begin
            if (lk_en) begin
                lk_data <= row_arr[lk_row];
            end
            if (rb_en) begin
                rb_data <= row_arr[rb_row];
            end
        end
    end
endmodule

// File: rtl/asmap_regif.sv
`timescale 1ns/1ps
// Physical register window: decode, table access strobes, one-cycle ack.
module asmap_regif
    import asmap_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int WIN_W  = 18,
    parameter int ASID_W = 6,
    parameter int IDX_W  = 11,
    parameter int EW     = 17,
    parameter int COLS   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     cfg_base,
    input  logic              reg_valid,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic              reg_ack,
    output logic [DW-1:0]     reg_rdata,
    output logic              pt_wr_en,
    output logic              pt_rb_en,
    output logic [IDX_W-1:0]  pt_idx,
    output logic [EW-1:0]     pt_wdata,
    input  logic [EW-1:0]     pt_rb_data,
    output logic              pm_wr_en,
    output logic              pm_rb_en,
    output logic [ASID_W-1:0] pm_row,
    output logic [COLS-1:0]   pm_wdata,
    input  logic [COLS-1:0]   pm_rb_data
);
    rg_state_e state_q, state_d;
    logic      sel_perm, hit, sel_perm_q;

    assign hit      = reg_valid && (reg_addr[AW-1:WIN_W] == cfg_base[AW-1:WIN_W]);
    assign sel_perm = reg_addr[WIN_W-1];

    assign pt_idx   = reg_addr[2 +: IDX_W];
    assign pm_row   = reg_addr[2 +: ASID_W];
    assign pt_wdata = reg_wdata[EW-1:0];
    assign pm_wdata = reg_wdata[COLS-1:0];
    assign pt_wr_en = hit && reg_we && !sel_perm;
    assign pm_wr_en = hit && reg_we && sel_perm;
    assign pt_rb_en = hit && !reg_we && !sel_perm;
    assign pm_rb_en = hit && !reg_we && sel_perm;

    always_comb begin
        state_d = RS_IDLE;
        if (hit) begin
            state_d = reg_we ? RS_WRITE : RS_READ;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= RS_IDLE;
            sel_perm_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            sel_perm_q <= sel_perm;
        end
    end

    always_comb begin
        reg_ack   = 1'b0;
        reg_rdata = '0;
        unique case (state_q)
            RS_IDLE: begin
                reg_ack = 1'b0;
            end
            RS_READ: begin
                reg_ack   = 1'b1;
                reg_rdata = sel_perm_q ? DW'(pm_rb_data) : DW'(pt_rb_data);
            end
            RS_WRITE: begin
                reg_ack = 1'b1;
            end
            default: begin
                reg_ack = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/asmap_xlate.sv
`timescale 1ns/1ps
// Translation stage: captures the request, ranks faults on the next cycle.
module asmap_xlate
    import asmap_pkg::*;
#(
    parameter int AW       = 32,
    parameter int ASID_W   = 6,
    parameter int OFF_W    = 16,
    parameter int PG_IDX_W = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [ASID_W-1:0]          req_asid,
    input  logic [AW-1:0]              req_va,
    input  logic                       req_we,
    input  logic                       req_io,
    output logic                       lk_en,
    output logic [ASID_W+PG_IDX_W-1:0] lk_idx,
    output logic [ASID_W-1:0]          lk_row,
    input  logic [AW-OFF_W:0]          pte,
    input  logic [(1<<PG_IDX_W)-1:0]   perm_row,
    output logic                       out_valid,
    output logic [AW-1:0]              out_pa,
    output logic                       out_we,
    output logic                       out_io,
    output logic                       flt_valid,
    output flt_cause_e                 flt_cause
);
    localparam int PFN_W = AW - OFF_W;
    localparam int HI    = OFF_W + PG_IDX_W;

    xl_state_e             state_q, state_d;
    logic [OFF_W-1:0]      off_q;
    logic [PG_IDX_W-1:0]   dev_q;
    logic                  we_q, io_q, range_q;
    logic                  range_bad;
    flt_cause_e            cause;

    assign range_bad = (req_va[AW-1:HI] != '0);
    assign lk_en     = req_valid;
    assign lk_idx    = {req_asid, req_va[OFF_W +: PG_IDX_W]};
    assign lk_row    = req_asid;

    always_comb begin
        state_d = req_valid ? XS_LOOKUP : XS_EMPTY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= XS_EMPTY;
            off_q   <= '0;
            dev_q   <= '0;
            we_q    <= 1'b0;
            io_q    <= 1'b0;
            range_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                off_q   <= req_va[OFF_W-1:0];
                dev_q   <= req_va[OFF_W +: PG_IDX_W];
                we_q    <= req_we;
                io_q    <= req_io;
                range_q <= range_bad;
            end
        end
    end

    always_comb begin
        cause = FLT_NONE;
        if (range_q) begin
            cause = FLT_RANGE;
        end else if (io_q && !perm_row[dev_q]) begin
            cause = FLT_IO_DENY;
        end else if (!pte[PFN_W]) begin
            cause = FLT_UNMAPPED;
        end
    end

    always_comb begin
        out_valid = 1'b0;
        flt_valid = 1'b0;
        flt_cause = FLT_NONE;
        unique case (state_q)
            XS_EMPTY: begin
                out_valid = 1'b0;
            end
            XS_LOOKUP: begin
                out_valid = (cause == FLT_NONE);
                flt_valid = (cause != FLT_NONE);
                flt_cause = cause;
            end
            default: begin
                out_valid = 1'b0;
            end
        endcase
        out_pa = {pte[PFN_W-1:0], off_q};
        out_we = we_q;
        out_io = io_q;
    end
endmodule

// File: rtl/asmap_top.sv
`timescale 1ns/1ps
module asmap_top
    import asmap_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int ASID_W   = 6,
    parameter int OFF_W    = 16,
    parameter int PG_IDX_W = 5,
    parameter int WIN_W    = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     cfg_base,
    input  logic              req_valid,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [AW-1:0]     req_va,
    input  logic              req_we,
    input  logic              req_io,
    output logic              out_valid,
    output logic [AW-1:0]     out_pa,
    output logic              out_we,
    output logic              out_io,
    output logic              flt_valid,
    output logic [1:0]        flt_cause,
    input  logic              reg_valid,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic              reg_ack,
    output logic [DW-1:0]     reg_rdata
);
    localparam int IDX_W = ASID_W + PG_IDX_W;
    localparam int EW    = AW - OFF_W + 1;
    localparam int COLS  = 1 << PG_IDX_W;

    logic              lk_en;
    logic [IDX_W-1:0]  lk_idx;
    logic [ASID_W-1:0] lk_row;
    logic [EW-1:0]     pte;
    logic [COLS-1:0]   perm_row;
    logic              pt_wr_en, pt_rb_en, pm_wr_en, pm_rb_en;
    logic [IDX_W-1:0]  pt_idx;
    logic [EW-1:0]     pt_wdata, pt_rb_data;
    logic [ASID_W-1:0] pm_row;
    logic [COLS-1:0]   pm_wdata, pm_rb_data;
    flt_cause_e        cause;

    asmap_xlate #(
        .AW(AW), .ASID_W(ASID_W), .OFF_W(OFF_W), .PG_IDX_W(PG_IDX_W)
    ) u_xlate (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_asid(req_asid), .req_va(req_va),
        .req_we(req_we), .req_io(req_io),
        .lk_en(lk_en), .lk_idx(lk_idx), .lk_row(lk_row),
        .pte(pte), .perm_row(perm_row),
        .out_valid(out_valid), .out_pa(out_pa), .out_we(out_we), .out_io(out_io),
        .flt_valid(flt_valid), .flt_cause(cause)
    );

    assign flt_cause = cause;

    asmap_ptab #(.IDX_W(IDX_W), .EW(EW)) u_ptab (
        .clk(clk),
        .lk_en(lk_en), .lk_idx(lk_idx), .lk_data(pte),
        .wr_en(pt_wr_en), .wr_idx(pt_idx), .wr_data(pt_wdata),
        .rb_en(pt_rb_en), .rb_idx(pt_idx), .rb_data(pt_rb_data)
    );

    asmap_perm #(.ROW_W(ASID_W), .COLS(COLS)) u_perm (
        .clk(clk), .rst_n(rst_n),
        .lk_en(lk_en), .lk_row(lk_row), .lk_data(perm_row),
        .wr_en(pm_wr_en), .wr_row(pm_row), .wr_data(pm_wdata),
        .rb_en(pm_rb_en), .rb_row(pm_row), .rb_data(pm_rb_data)
    );

    asmap_regif #(
        .AW(AW), .DW(DW), .WIN_W(WIN_W), .ASID_W(ASID_W),
        .IDX_W(IDX_W), .EW(EW), .COLS(COLS)
    ) u_regif (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base),
        .reg_valid(reg_valid), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
        .pt_wr_en(pt_wr_en), .pt_rb_en(pt_rb_en), .pt_idx(pt_idx),
        .pt_wdata(pt_wdata), .pt_rb_data(pt_rb_data),
        .pm_wr_en(pm_wr_en), .pm_rb_en(pm_rb_en), .pm_row(pm_row),
        .pm_wdata(pm_wdata), .pm_rb_data(pm_rb_data)
    );
endmodule

// File: rtl/asmap_checker.sv
`timescale 1ns/1ps
module asmap_checker #(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int ASID_W   = 6,
    parameter int OFF_W    = 16,
    parameter int PG_IDX_W = 5,
    parameter int WIN_W    = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AW-1:0]     cfg_base,
    input logic              req_valid,
    input logic [ASID_W-1:0] req_asid,
    input logic [AW-1:0]     req_va,
    input logic              req_we,
    input logic              req_io,
    input logic              out_valid,
    input logic [AW-1:0]     out_pa,
    input logic              out_we,
    input logic              out_io,
    input logic              flt_valid,
    input logic [1:0]        flt_cause,
    input logic              reg_valid,
    input logic              reg_we,
    input logic [AW-1:0]     reg_addr,
    input logic [DW-1:0]     reg_wdata,
    input logic              reg_ack,
    input logic [DW-1:0]     reg_rdata
);
    localparam int HI = OFF_W + PG_IDX_W;

    logic win_hit;
    assign win_hit = reg_valid && (reg_addr[AW-1:WIN_W] == cfg_base[AW-1:WIN_W]);

    p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (out_valid || flt_valid));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && !flt_valid));

    p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && flt_valid));

    p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!out_valid || (out_pa[OFF_W-1:0] == $past(req_va[OFF_W-1:0]))));

    p_flags_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!out_valid || (out_we == $past(req_we) && out_io == $past(req_io))));

    p_range_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_va[AW-1:HI] != '0)) |=> (flt_valid && flt_cause == 2'd1));

    p_mem_no_deny_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_io) |=> (flt_cause != 2'd2));

    p_ack_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |=> reg_ack);

    p_ack_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !win_hit |=> !reg_ack);
endmodule

bind asmap_top asmap_checker #(
    .AW(AW), .DW(DW), .ASID_W(ASID_W), .OFF_W(OFF_W),
    .PG_IDX_W(PG_IDX_W), .WIN_W(WIN_W)
) u_chk (.*);

// File: tb/asmap_top_test.sv
`timescale 1ns/1ps
module asmap_top_test;
    localparam logic [31:0] BASE  = 32'hFFF4_0000;
    localparam logic [31:0] PERMO = 32'h0002_0000;
    localparam int NV = 12;
    // {asid[6], va[32], io, we, cause[2], pa[32]} = 74 bits
    localparam logic [73:0] VEC [NV] = '{
        {6'd1, 32'h0000_1234, 1'b0, 1'b0, 2'd0, 32'h1234_1234}, // R2
        {6'd1, 32'h0003_FFFF, 1'b1, 1'b1, 2'd0, 32'h0040_FFFF}, // R5 allowed
        {6'd2, 32'h0000_0010, 1'b0, 1'b1, 2'd0, 32'h7777_0010}, // R3
        {6'd1, 32'h0020_0000, 1'b0, 1'b0, 2'd1, 32'h0},         // R4
        {6'd1, 32'h0004_0000, 1'b0, 1'b0, 2'd3, 32'h0},         // R6
        {6'd2, 32'h0005_0008, 1'b1, 1'b0, 2'd2, 32'h0},         // R5 denied
        {6'd2, 32'h0005_0008, 1'b0, 1'b0, 2'd0, 32'h0005_0008}, // R5 mem ignores
        {6'd1, 32'h8000_0000, 1'b1, 1'b0, 2'd1, 32'h0},         // R7 range first
        {6'd1, 32'h0004_0000, 1'b1, 1'b0, 2'd2, 32'h0},         // R7 deny before unmapped
        {6'd1, 32'h001F_0001, 1'b0, 1'b0, 2'd0, 32'hABCD_0001}, // R3 last page
        {6'd3, 32'h0000_0100, 1'b1, 1'b0, 2'd2, 32'h0},         // R1 reset deny
        {6'd3, 32'h0000_0100, 1'b0, 1'b0, 2'd0, 32'h0300_0100}  // R3
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [31:0] cfg_base = BASE;
    logic req_valid = 0, req_we = 0, req_io = 0;
    logic [5:0] req_asid = '0;
    logic [31:0] req_va = '0;
    logic out_valid, out_we, out_io, flt_valid, reg_ack;
    logic [31:0] out_pa, reg_rdata;
    logic [1:0] flt_cause;
    logic reg_valid = 0, reg_we = 0;
    logic [31:0] reg_addr = '0, reg_wdata = '0;
    int n_tests = 0, n_fail = 0;
    logic ack;
    logic [31:0] rd;

    always #2.5 clk = ~clk;

    asmap_top uut (.*);

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_op(input logic we, input logic [31:0] a, input logic [31:0] d,
                          output logic ak, output logic [31:0] r);
        @(negedge clk);
        reg_valid = 1; reg_we = we; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 0; reg_we = 0;
        ak = reg_ack; r = reg_rdata;
    endtask

    function automatic logic [31:0] pt_addr(input int asid, input int pg);
        return BASE | 32'((asid * 32 + pg) * 4);
    endfunction

    task automatic xlate(input logic [5:0] s, input logic [31:0] va, input logic io, input logic we);
        @(negedge clk);
        req_valid = 1; req_asid = s; req_va = va; req_io = io; req_we = we;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic expect_out(input string tag, input logic [1:0] c, input logic [31:0] pa,
                              input logic io, input logic we);
        if (c == 2'd0) begin
            check(out_valid && !flt_valid, tag, {30'd0, out_valid, flt_valid}, 32'h2);
            check(out_pa == pa, tag, out_pa, pa);
            check(out_io == io && out_we == we, tag, {30'd0, out_io, out_we}, {30'd0, io, we});
        end else begin
            check(flt_valid && !out_valid, tag, {30'd0, out_valid, flt_valid}, 32'h1);
            check(flt_cause == c, tag, {30'd0, flt_cause}, {30'd0, c});
        end
    endtask

    initial begin
        #(200000 * 5);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(!out_valid && !flt_valid && !reg_ack, "R1 reset outputs",
              {29'd0, out_valid, flt_valid, reg_ack}, 32'h0);

        // table setup (R9 layout)
        reg_op(1, pt_addr(1, 0),  32'h0001_1234, ack, rd);
        check(ack, "R9 write ack", {31'd0, ack}, 32'h1);
        reg_op(1, pt_addr(1, 3),  32'h0001_0040, ack, rd);
        reg_op(1, pt_addr(1, 4),  32'h0000_0000, ack, rd);
        reg_op(1, pt_addr(1, 31), 32'h0001_ABCD, ack, rd);
        reg_op(1, pt_addr(2, 0),  32'h0001_7777, ack, rd);
        reg_op(1, pt_addr(2, 5),  32'h0001_0005, ack, rd);
        reg_op(1, pt_addr(3, 0),  32'h0001_0300, ack, rd);
        reg_op(1, BASE | PERMO | 32'(1 * 4), 32'h0000_0008, ack, rd);

        reg_op(0, pt_addr(1, 0), 32'h0, ack, rd);
        check(ack && rd == 32'h0001_1234, "R9 page readback", rd, 32'h0001_1234);
        reg_op(0, BASE | PERMO | 32'(1 * 4), 32'h0, ack, rd);
        check(ack && rd == 32'h0000_0008, "R9 perm readback", rd, 32'h8);

        for (int i = 0; i < NV; i++) begin
            xlate(VEC[i][73:68], VEC[i][67:36], VEC[i][35], VEC[i][34]);
            expect_out($sformatf("vec%0d R2/R3/R4/R5/R6/R7", i), VEC[i][33:32], VEC[i][31:0],
                       VEC[i][35], VEC[i][34]);
        end

        // R8: write through a non-matching base is ignored
        reg_op(1, 32'h1234_0000 | PERMO | 32'(2 * 4), 32'hFFFF_FFFF, ack, rd);
        check(!ack, "R8 miss no ack", {31'd0, ack}, 32'h0);
        xlate(6'd2, 32'h0005_0008, 1'b1, 1'b0);
        expect_out("R8 miss no write", 2'd2, 32'h0, 1'b1, 1'b0);
        reg_op(0, BASE | PERMO | 32'(2 * 4), 32'h0, ack, rd);
        check(rd == 32'h0, "R8 perm row untouched", rd, 32'h0);

        // R10 idle: no request -> nothing
        @(negedge clk);
        check(!out_valid && !flt_valid, "R10 idle", {30'd0, out_valid, flt_valid}, 32'h0);

        // R11 back-to-back
        @(negedge clk);
        req_valid = 1; req_asid = 6'd1; req_va = 32'h0000_0005; req_io = 0; req_we = 0;
        @(negedge clk);
        req_asid = 6'd2; req_va = 32'h0000_0006;
        check(out_valid && out_pa == 32'h1234_0005, "R11 first", out_pa, 32'h1234_0005);
        @(negedge clk);
        req_valid = 0;
        check(out_valid && out_pa == 32'h7777_0006, "R11 second", out_pa, 32'h7777_0006);

        // R12 write/lookup collision
        @(negedge clk);
        req_valid = 1; req_asid = 6'd2; req_va = 32'h0000_0000; req_io = 0;
        reg_valid = 1; reg_we = 1; reg_addr = pt_addr(2, 0); reg_wdata = 32'h0001_1111;
        @(negedge clk);
        req_valid = 0; reg_valid = 0; reg_we = 0;
        check(out_valid && out_pa == 32'h7777_0000, "R12 old entry", out_pa, 32'h7777_0000);
        xlate(6'd2, 32'h0000_0000, 1'b0, 1'b0);
        check(out_valid && out_pa == 32'h1111_0000, "R12 new entry", out_pa, 32'h1111_0000);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule